// File: doc/BRIEF.md
# ECC Strength Configuration Calculator

This block sizes a BCH-style NAND error-correction setup for a single sector. It is given the sector message length in bytes and the number of spare bytes that may hold parity. From the message length it works out how many parity bits each correctable error costs. It then picks the strongest correction level from a fixed list whose parity still fits in the spare budget. Finally it packs the two configuration words that an encoder and a decoder need for that choice.

A request is started with a one-cycle `start_i` pulse. The block then checks one entry of the capability list per clock, starting at the strongest. It raises `done_o` for one cycle when it finds a match or when it runs out of entries. All results are held until the next accepted request. The BCH arithmetic itself is not part of this block.

Top module: `ecc_strength_calc`

## Requirements
- R1: After a request, `parity_bits_o` equals the 1-based position of the highest set bit of (1 + 8 × message bytes).
- R2: The selected strength is the largest entry of the list {4, 6, 8, 10, 12} (index 0 to 4) for which strength × parity bits ≤ 8 × maximum ECC bytes. `strength_idx_o` reports the index of that entry.
- R3: When even strength 4 does not fit, `unsupported_o` is 1 and the strength, index, ECC byte count and both configuration words are all 0. Otherwise `unsupported_o` is 0.
- R4: `ecc_bytes_o` equals ceil(strength × parity bits / 8).
- R5: The encoder word holds the message length in bits at bit 16 upward, the value 1 in bits [7:4], and the strength index in bits [3:0]. All other bits are 0.
- R6: The decoder word has bit 31 set and holds (message bits + strength × parity bits) in bits [30:16]. It holds the value 3 in bits [13:12], the value 1 in bits [7:4], and the strength index in bits [3:0]. All other bits are 0.
- R7: `done_o` is a single-cycle pulse. It is seen (5 − index) cycles after the clock edge that accepts `start_i`, or 5 cycles after that edge when the request is unsupported.
- R8: Between requests, all result outputs stay unchanged even when the request inputs change.
- R9: A `start_i` pulse that arrives while a search is in progress is ignored. The results and the timing of the running request are unaffected.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only when idle |
| msg_bytes_i | input | MSG_W (11) | Sector message length in bytes |
| max_ecc_bytes_i | input | SPARE_W (8) | Spare bytes available for parity |
| done_o | output | 1 | One-cycle completion pulse |
| unsupported_o | output | 1 | No list entry fits the budget |
| strength_o | output | CAP_W (4) | Selected correctable-error count |
| strength_idx_o | output | IDX_W (3) | Index of the selected entry |
| parity_bits_o | output | PAR_W (4) | Parity bits per correctable error |
| ecc_bytes_o | output | SPARE_W (8) | Parity bytes for the chosen strength |
| enc_cfg_o | output | 32 | Encoder configuration word |
| dec_cfg_o | output | 32 | Decoder configuration word |

## Verification
The assertions assume the following about the inputs:
- The message length never exceeds 2047 bytes, so the codeword length always fits the 15-bit decoder field.
- `start_i` is released after one cycle.

Random requests draw the message length and the spare budget within the port widths. Directed cases cover:
- a zero budget;
- budgets exactly at and just below a strength boundary;
- the largest message.

Requests injected while a search is running check that the held inputs are not overwritten.

// File: rtl/ecc_cfg_pkg.sv
package ecc_cfg_pkg;
  localparam int unsigned CAP_BASE    = 4;
  localparam int unsigned CAP_STEP    = 2;
  localparam int unsigned ENC_LEN_LSB = 16;
  localparam int unsigned DEC_LEN_LSB = 16;
  localparam int unsigned DEC_LEN_W   = 15;
  localparam int unsigned MODE_LSB    = 4;
  localparam int unsigned CORR_LSB    = 12;
  localparam int unsigned EMPTY_BIT   = 31;
  localparam logic [31:0] MODE_VAL    = 32'd1;
  localparam logic [31:0] CORR_VAL    = 32'd3;

  function automatic int unsigned cap_of(input int unsigned idx);
    return CAP_BASE + CAP_STEP * idx;
  endfunction
endpackage

// File: rtl/ecc_par_width.sv
module ecc_par_width #(
  parameter int unsigned VW = 14,
  parameter int unsigned PW = 4
) (
  input  logic [VW-1:0] val_i,
  output logic [PW-1:0] msb_pos_o
);
  always_comb begin
    msb_pos_o = '0;
    for (int i = 0; i < VW; i++)
      if (val_i[i]) msb_pos_o = PW'(i + 1);
  end
endmodule

// File: rtl/ecc_cfg_pack.sv
module ecc_cfg_pack
  import ecc_cfg_pkg::*;
#(
  parameter int unsigned MSG_W  = 11,
  parameter int unsigned PAR_W  = 4,
  parameter int unsigned CAP_W  = 4,
  parameter int unsigned IDX_W  = 3,
  parameter int unsigned ECCB_W = 8
) (
  input  logic [MSG_W-1:0]  msg_bytes_i,
  input  logic [CAP_W-1:0]  cap_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [PAR_W-1:0]  par_i,
  output logic [ECCB_W-1:0] ecc_bytes_o,
  output logic [31:0]       enc_cfg_o,
  output logic [31:0]       dec_cfg_o
);
  localparam logic [31:0] LEN_MASK = (32'd1 << DEC_LEN_W) - 32'd1;

  logic [31:0] par_bits_tot, msg_bits, cw_bits;

  always_comb begin
    par_bits_tot = 32'(cap_i) * 32'(par_i);
    msg_bits     = 32'(msg_bytes_i) << 3;
    cw_bits      = msg_bits + par_bits_tot;
    ecc_bytes_o  = ECCB_W'((par_bits_tot + 32'd7) >> 3);
    enc_cfg_o    = (msg_bits << ENC_LEN_LSB) | (MODE_VAL << MODE_LSB) | 32'(idx_i);
    dec_cfg_o    = (32'd1 << EMPTY_BIT) | ((cw_bits & LEN_MASK) << DEC_LEN_LSB)
                 | (CORR_VAL << CORR_LSB) | (MODE_VAL << MODE_LSB) | 32'(idx_i);
  end
endmodule

// File: rtl/ecc_strength_calc.sv
module ecc_strength_calc
  import ecc_cfg_pkg::*;
#(
  parameter int unsigned MSG_W   = 11,
  parameter int unsigned SPARE_W = 8,
  parameter int unsigned NCAP    = 5,
  parameter int unsigned IDX_W   = $clog2(NCAP) < 1 ? 1 : $clog2(NCAP),
  parameter int unsigned CAP_W   = $clog2(CAP_BASE + CAP_STEP * (NCAP - 1) + 1),
  parameter int unsigned PAR_W   = $clog2(MSG_W + 4)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [MSG_W-1:0]   msg_bytes_i,
  input  logic [SPARE_W-1:0] max_ecc_bytes_i,
  output logic               done_o,
  output logic               unsupported_o,
  output logic [CAP_W-1:0]   strength_o,
  output logic [IDX_W-1:0]   strength_idx_o,
  output logic [PAR_W-1:0]   parity_bits_o,
  output logic [SPARE_W-1:0] ecc_bytes_o,
  output logic [31:0]        enc_cfg_o,
  output logic [31:0]        dec_cfg_o
);
  localparam int unsigned VW    = MSG_W + 3;
  localparam int unsigned PROD_W = CAP_W + PAR_W;
  localparam int unsigned BUD_W  = SPARE_W + 3;
  localparam int unsigned CMP_W  = (PROD_W > BUD_W) ? PROD_W : BUD_W;

  logic               busy_q;
  logic [IDX_W-1:0]   idx_q;
  logic [MSG_W-1:0]   msg_q;
  logic [SPARE_W-1:0] spare_q;

  logic [PAR_W-1:0]   par;
  logic [CAP_W-1:0]   cap_cur;
  logic               fits;
  logic [SPARE_W-1:0] eccb_cur;
  logic [31:0]        enc_cur, dec_cur;

  ecc_par_width #(.VW(VW), .PW(PAR_W)) u_par (
    .val_i     ({msg_q, 3'b001}),
    .msb_pos_o (par)
  );

  always_comb begin
    cap_cur = CAP_W'(cap_of(32'(idx_q)));
    fits    = CMP_W'(cap_cur * PROD_W'(par)) <= CMP_W'({spare_q, 3'b000});
  end

  ecc_cfg_pack #(
    .MSG_W(MSG_W), .PAR_W(PAR_W), .CAP_W(CAP_W), .IDX_W(IDX_W), .ECCB_W(SPARE_W)
  ) u_pack (
    .msg_bytes_i (msg_q),
    .cap_i       (cap_cur),
    .idx_i       (idx_q),
    .par_i       (par),
    .ecc_bytes_o (eccb_cur),
    .enc_cfg_o   (enc_cur),
    .dec_cfg_o   (dec_cur)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q         <= 1'b0;
      idx_q          <= '0;
      msg_q          <= '0;
      spare_q        <= '0;
      done_o         <= 1'b0;
      unsupported_o  <= 1'b0;
      strength_o     <= '0;
      strength_idx_o <= '0;
      parity_bits_o  <= '0;
      ecc_bytes_o    <= '0;
      enc_cfg_o      <= '0;
      dec_cfg_o      <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          idx_q   <= IDX_W'(NCAP - 1);
          msg_q   <= msg_bytes_i;
          spare_q <= max_ecc_bytes_i;
        end
      end else if (fits) begin
        busy_q         <= 1'b0;
        done_o         <= 1'b1;
        unsupported_o  <= 1'b0;
        strength_o     <= cap_cur;
        strength_idx_o <= idx_q;
        parity_bits_o  <= par;
        ecc_bytes_o    <= eccb_cur;
        enc_cfg_o      <= enc_cur;
        dec_cfg_o      <= dec_cur;
      end else if (idx_q == '0) begin
        busy_q         <= 1'b0;
        done_o         <= 1'b1;
        unsupported_o  <= 1'b1;
        strength_o     <= '0;
        strength_idx_o <= '0;
        parity_bits_o  <= par;
        ecc_bytes_o    <= '0;
        enc_cfg_o      <= '0;
        dec_cfg_o      <= '0;
      end else begin
        idx_q <= idx_q - 1'b1;
      end
    end
  end

  // selected strength must fit the latched budget
  p_fit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !unsupported_o |->
      32'(strength_o) * 32'(parity_bits_o) <= 32'(spare_q) * 32'd8);

  p_unsup_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && unsupported_o |-> enc_cfg_o == '0 && dec_cfg_o == '0 && strength_o == '0);

  p_dec_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !unsupported_o |-> dec_cfg_o[31] && dec_cfg_o[13:12] == 2'b11);

  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(enc_cfg_o) && $stable(dec_cfg_o) && $stable(strength_o));

  p_ignore_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(msg_q) && $stable(spare_q));
endmodule

// File: tb/tb_ecc_strength_calc.sv
module tb_ecc_strength_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] msg = '0;
  logic [7:0]  spare = '0;
  logic        done, unsup;
  logic [3:0]  strength;
  logic [2:0]  sidx;
  logic [3:0]  par;
  logic [7:0]  eccb;
  logic [31:0] enc, dec;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ecc_strength_calc dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .msg_bytes_i(msg), .max_ecc_bytes_i(spare),
    .done_o(done), .unsupported_o(unsup), .strength_o(strength),
    .strength_idx_o(sidx), .parity_bits_o(par), .ecc_bytes_o(eccb),
    .enc_cfg_o(enc), .dec_cfg_o(dec)
  );

  function automatic int unsigned fls(input int unsigned v);
    int unsigned r = 0;
    for (int i = 0; i < 32; i++) if (v[i]) r = i + 1;
    return r;
  endfunction

  // returns -1 when unsupported
  function automatic int pick(input int unsigned p, input int unsigned s);
    for (int i = 4; i >= 0; i--) if ((4 + 2 * i) * p <= 8 * s) return i;
    return -1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int unsigned m, input int unsigned s, input bit inject);
    int unsigned p, st, eb;
    int i, cyc, lat;
    logic [31:0] e_enc, e_dec;
    p = fls(1 + 8 * m);
    i = pick(p, s);
    st = (i < 0) ? 0 : 4 + 2 * i;
    eb = (st * p + 7) / 8;
    e_enc = (i < 0) ? 0 : (((m * 8) << 16) | 32'h10 | i);
    e_dec = (i < 0) ? 0 : (32'h8000_0000 | (((m * 8 + st * p) & 32'h7fff) << 16)
                          | 32'h3000 | 32'h10 | i);
    lat = (i < 0) ? 5 : 5 - i;
    @(negedge clk);
    msg = 11'(m); spare = 8'(s); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    if (inject) begin  // R9: second start while busy
      msg = ~msg; spare = 8'd255; start = 1'b1;
    end
    while (!done && cyc < 50) begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end
    chk(inject ? "R9/R7 latency" : "R7 latency", 32'(cyc), 32'(lat));
    chk("R1 parity", 32'(par), p);
    chk("R2 strength", 32'(strength), st);
    chk("R2 index", 32'(sidx), (i < 0) ? 0 : i);
    chk("R3 unsupported", 32'(unsup), (i < 0) ? 1 : 0);
    chk("R4 ecc bytes", 32'(eccb), eb);
    chk("R5 enc word", enc, e_enc);
    chk("R6 dec word", dec, e_dec);
    // R7: done is a single-cycle pulse
    @(negedge clk);
    chk("R7 pulse", 32'(done), 0);
    // R8: change inputs without start; results must hold
    msg = 11'($urandom); spare = 8'($urandom);
    repeat (3) @(negedge clk);
    chk("R8 hold enc", enc, e_enc);
    chk("R8 hold dec", dec, e_dec);
    chk("R8 hold strength", 32'(strength), st);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 done", 32'(done), 0);
    chk("R10 enc", enc, 0);
    chk("R10 dec", dec, 0);
    chk("R10 strength", 32'(strength), 0);
    chk("R10 unsup", 32'(unsup), 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(512, 0, 0);    // R3 zero budget
    run(512, 6, 0);    // R3 48 < 52
    run(512, 7, 0);    // R2 exactly strength 4 fits
    run(512, 9, 0);    // R2 78 > 72 boundary
    run(512, 10, 0);   // R2 strength 6
    run(1024, 255, 0); // R2 top strength
    run(2047, 21, 0);  // R6 max message, 12*14=168
    run(2047, 20, 1);  // R9 with injection
    run(0, 1, 0);      // R1 parity 1
    for (int k = 0; k < 60; k++)
      run($urandom_range(0, 2047), $urandom_range(0, 255), k[2]);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule